// File: doc/BRIEF.md
# Strobed Parallel Port Pair with Shared Interrupt

This block provides two 8-bit bidirectional parallel ports that a host reaches through a small synchronous register bus. Each line of each port is steered by its own direction bit. An output line drives the value held in the port's output register. An input line leaves the pad to the outside world. On the pad side, each port has separate input, output and output-enable vectors, plus one strobe input.

Each port also watches its strobe. When the strobe makes the selected transition, the port copies its eight pad inputs into a capture register and marks the capture as pending. If the port's interrupt enable is set, a pending capture pulls the shared active-low interrupt line. When the host reads the capture register, the pending mark is cleared. Both ports drive the single interrupt output, so the host reads the control register of each port to find out which one raised the request. The strobe and the pad inputs are asynchronous and are synchronized inside the block. A capture therefore becomes visible three clock edges after the strobe moves.

Top module: `strb_port_pair`

## Requirements
- R1: After a synchronous reset, every register reads zero, pad_out and pad_oe are zero on both ports, and irq_n is high.
- R2: The output register (address 0) drives pad_out and the direction register (address 1) drives pad_oe bit for bit, where 1 means output. Both registers read back what was written.
- R3: With control bit 1 clear, a rising strobe copies pad_in into the capture register (address 2) and sets the pending flag, which is control bit 7. With control bit 1 set, a falling strobe does the same. Both effects are visible at the third rising clock edge after the strobe changes.
- R4: A strobe transition in the non-selected direction changes neither the capture register nor the pending flag.
- R5: The capture register keeps its value while pad_in changes, for as long as no selected strobe edge arrives.
- R6: A bus read of the capture register clears the pending flag. Reading or writing the control register does not change the flag, because bit 7 cannot be written.
- R7: If a strobe capture and a read of the capture register fall in the same cycle, the read returns the previous capture and the pending flag stays set.
- R8: A port requests an interrupt only when its pending flag and its enable (control bit 0) are both set. A pending capture with the enable clear leaves irq_n high.
- R9: irq_n is low while either port requests and goes high only when neither port does.
- R10: bus_sel picks the port (0 is port A, 1 is port B). Accesses to one port leave the other port's registers and pads unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Port select, 0 for A and 1 for B |
| bus_addr | input | 2 | Register select: 0 output, 1 direction, 2 capture, 3 control |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle; needed for the clear side effect |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the selected register |
| a_pad_in | input | 8 | Port A pad input levels |
| a_pad_out | output | 8 | Port A pad output values |
| a_pad_oe | output | 8 | Port A per-line output enables |
| a_strobe | input | 1 | Port A capture strobe, asynchronous |
| b_pad_in | input | 8 | Port B pad input levels |
| b_pad_out | output | 8 | Port B pad output values |
| b_pad_oe | output | 8 | Port B per-line output enables |
| b_strobe | input | 1 | Port B capture strobe, asynchronous |
| irq_n | output | 1 | Shared active-low interrupt request |

## Verification
The assertions check on every cycle that a detected strobe edge always leaves the pending flag set, and that a capture read with no competing edge always clears it. They also check that the capture register holds whenever no edge arrives, that control writes never change the flag, and that a direction write reaches pad_oe on the next cycle. Some behaviour can only be shown by the bench's scenarios:
- the three-edge latency from the pad to the flag
- edges in the wrong direction being ignored in both polarity modes
- the same-cycle race between a read and a capture
- the interrupt line staying low until the last of the two ports is serviced

// File: rtl/strb_port_pkg.sv
package strb_port_pkg;

    typedef enum logic [1:0] {
        REG_OUT   = 2'd0,
        REG_DIR   = 2'd1,
        REG_LATCH = 2'd2,
        REG_CTRL  = 2'd3
    } reg_sel_e;

    localparam int CTRL_IE_BIT   = 0;
    localparam int CTRL_FALL_BIT = 1;

    typedef struct packed {
        logic seen;
        logic falling;
        logic ie;
    } ctrl_t;

    function automatic logic strobe_edge(logic prev, logic cur, logic falling);
        return falling ? (prev & ~cur) : (~prev & cur);
    endfunction

endpackage

// File: rtl/strb_port_sync.sv
module strb_port_sync #(
    parameter int W      = 9,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/strb_port_lane.sv
module strb_port_lane
    import strb_port_pkg::*;
#(
    parameter int W    = 8,
    parameter int SYNC = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sel,
    input  logic [1:0]   addr,
    input  logic         wr,
    input  logic         rd,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    input  logic         strobe,
    output logic         req
);
    localparam int SW = W + 1;

    logic [W-1:0]  out_q, dir_q, latch_q;
    ctrl_t         ctrl_q;
    logic          stb_prev;
    logic [SW-1:0] sync_q;
    logic          stb_s;
    logic [W-1:0]  pins_s;
    logic          edge_hit;
    logic          rd_latch;
    reg_sel_e      rsel;

    strb_port_sync #(.W(SW), .STAGES(SYNC)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({strobe, pad_in}),
        .q   (sync_q)
    );

    assign stb_s    = sync_q[SW-1];
    assign pins_s   = sync_q[W-1:0];
    assign rsel     = reg_sel_e'(addr);
    assign edge_hit = strobe_edge(stb_prev, stb_s, ctrl_q.falling);
    assign rd_latch = sel && rd && (rsel == REG_LATCH);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q      <= '0;
            dir_q      <= '0;
            ctrl_q.ie      <= 1'b0;
            ctrl_q.falling <= 1'b0;
        end else if (sel && wr) begin
            case (rsel)
                REG_OUT:  out_q <= wdata;
                REG_DIR:  dir_q <= wdata;
                REG_CTRL: begin
                    ctrl_q.ie      <= wdata[CTRL_IE_BIT];
                    ctrl_q.falling <= wdata[CTRL_FALL_BIT];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_prev    <= 1'b0;
            latch_q     <= '0;
            ctrl_q.seen <= 1'b0;
        end else begin
            stb_prev <= stb_s;
            if (edge_hit) begin
                latch_q     <= pins_s;
                ctrl_q.seen <= 1'b1;
            end else if (rd_latch) begin
                ctrl_q.seen <= 1'b0;
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (rsel)
            REG_OUT:   rdata = out_q;
            REG_DIR:   rdata = dir_q;
            REG_LATCH: rdata = latch_q;
            REG_CTRL: begin
                rdata[CTRL_IE_BIT]   = ctrl_q.ie;
                rdata[CTRL_FALL_BIT] = ctrl_q.falling;
                rdata[W-1]           = ctrl_q.seen;
            end
            default: rdata = '0;
        endcase
    end

    assign pad_out = out_q;
    assign pad_oe  = dir_q;
    assign req     = ctrl_q.seen & ctrl_q.ie;

    assert_edge_sets_R3: assert property (@(posedge clk) disable iff (rst)
        edge_hit |=> ctrl_q.seen);

    assert_read_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_latch && !edge_hit) |=> !ctrl_q.seen);

    assert_latch_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !edge_hit |=> $stable(latch_q));

    assert_ctrl_keeps_flag_R6: assert property (@(posedge clk) disable iff (rst)
        (sel && wr && rsel == REG_CTRL && !edge_hit && !rd_latch) |=> $stable(ctrl_q.seen));

    assert_dir_to_oe_R2: assert property (@(posedge clk) disable iff (rst)
        (sel && wr && rsel == REG_DIR) |=> (pad_oe == $past(wdata)));
endmodule

// File: rtl/strb_port_irq.sv
module strb_port_irq #(
    parameter int N = 2
) (
    input  logic [N-1:0] req,
    output logic         irq_n
);
    assign irq_n = ~(|req);
endmodule

// File: rtl/strb_port_pair.sv
module strb_port_pair
    import strb_port_pkg::*;
#(
    parameter int W    = 8,
    parameter int SYNC = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bus_sel,
    input  logic [1:0]   bus_addr,
    input  logic         bus_wr,
    input  logic         bus_rd,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic [W-1:0] a_pad_in,
    output logic [W-1:0] a_pad_out,
    output logic [W-1:0] a_pad_oe,
    input  logic         a_strobe,
    input  logic [W-1:0] b_pad_in,
    output logic [W-1:0] b_pad_out,
    output logic [W-1:0] b_pad_oe,
    input  logic         b_strobe,
    output logic         irq_n
);
    localparam int NP = 2;

    logic [W-1:0] pin_in  [NP];
    logic [W-1:0] pin_out [NP];
    logic [W-1:0] pin_oe  [NP];
    logic [W-1:0] rd_mux  [NP];
    logic [NP-1:0] stb;
    logic [NP-1:0] req;

    assign pin_in[0] = a_pad_in;
    assign pin_in[1] = b_pad_in;
    assign stb       = {b_strobe, a_strobe};

    generate
        for (genvar p = 0; p < NP; p++) begin : g_port
            strb_port_lane #(.W(W), .SYNC(SYNC)) u_lane (
                .clk     (clk),
                .rst     (rst),
                .sel     (bus_sel == p[0]),
                .addr    (bus_addr),
                .wr      (bus_wr),
                .rd      (bus_rd),
                .wdata   (bus_wdata),
                .rdata   (rd_mux[p]),
                .pad_in  (pin_in[p]),
                .pad_out (pin_out[p]),
                .pad_oe  (pin_oe[p]),
                .strobe  (stb[p]),
                .req     (req[p])
            );
        end
    endgenerate

    assign bus_rdata = rd_mux[bus_sel];
    assign a_pad_out = pin_out[0];
    assign a_pad_oe  = pin_oe[0];
    assign b_pad_out = pin_out[1];
    assign b_pad_oe  = pin_oe[1];

    strb_port_irq #(.N(NP)) u_irq (
        .req   (req),
        .irq_n (irq_n)
    );

    assert_unselected_stable_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_sel) |=> $stable(a_pad_out) && $stable(a_pad_oe));
endmodule

// File: tb/strb_port_pair_tb.sv
module strb_port_pair_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] a_pad_in = 8'h00, b_pad_in = 8'h00;
    logic [7:0] a_pad_out, a_pad_oe, b_pad_out, b_pad_oe;
    logic       a_strobe = 1'b0, b_strobe = 1'b0;
    logic       irq_n;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } exp_item_t;
    exp_item_t sb_q[$];

    always #4 clk = ~clk;

    strb_port_pair u_dut (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .a_pad_in(a_pad_in), .a_pad_out(a_pad_out), .a_pad_oe(a_pad_oe), .a_strobe(a_strobe),
        .b_pad_in(b_pad_in), .b_pad_out(b_pad_out), .b_pad_oe(b_pad_oe), .b_strobe(b_strobe),
        .irq_n(irq_n)
    );

    task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    // monitor: pops the expected read value mid-cycle while a read is on the bus
    always @(negedge clk) begin
        if (bus_rd) begin
            if (sb_q.size() == 0) begin
                vectors++;
                miscompares++;
                $display("FAIL scoreboard: read with no expected item, got %02h expected none", bus_rdata);
            end else begin
                exp_item_t it;
                it = sb_q.pop_front();
                check(bus_rdata, it.exp, it.tag);
            end
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic bus_write(input logic p, input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_sel = p; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic p, input logic [1:0] a, input logic [7:0] exp, input string tag);
        @(posedge clk); #1;
        bus_sel = p; bus_addr = a; bus_rd = 1'b1;
        sb_q.push_back('{exp: exp, tag: tag});
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    initial begin
        #(8 * 20000);
        if (!finished) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        // R1 reset state
        check(a_pad_out, 8'h00, "R1 a_pad_out");
        check(a_pad_oe,  8'h00, "R1 a_pad_oe");
        check(b_pad_oe,  8'h00, "R1 b_pad_oe");
        check({7'd0, irq_n}, 8'h01, "R1 irq_n");
        bus_read(0, 2'd3, 8'h00, "R1 ctrl A");
        bus_read(1, 2'd2, 8'h00, "R1 capture B");

        // R2 output and direction, R10 isolation
        bus_write(0, 2'd0, 8'hA5);
        bus_write(0, 2'd1, 8'h0F);
        check(a_pad_out, 8'hA5, "R2 a_pad_out");
        check(a_pad_oe,  8'h0F, "R2 a_pad_oe");
        check(b_pad_out, 8'h00, "R10 b_pad_out untouched");
        check(b_pad_oe,  8'h00, "R10 b_pad_oe untouched");
        bus_read(0, 2'd0, 8'hA5, "R2 out readback");
        bus_read(0, 2'd1, 8'h0F, "R2 dir readback");
        bus_read(1, 2'd1, 8'h00, "R10 dir B readback");

        // R3 rising capture, R8 enable off
        b_pad_in = 8'h3C;
        step(3);
        b_strobe = 1'b1;
        step(4);
        bus_read(1, 2'd3, 8'h80, "R3 pending after rising edge");
        check({7'd0, irq_n}, 8'h01, "R8 no irq while enable clear");
        bus_write(1, 2'd3, 8'h01);
        check({7'd0, irq_n}, 8'h00, "R8 irq with enable set");
        bus_read(1, 2'd3, 8'h81, "R6 ctrl write keeps pending");
        bus_read(1, 2'd2, 8'h3C, "R3 captured value");
        check({7'd0, irq_n}, 8'h01, "R6 irq released after read");
        bus_read(1, 2'd3, 8'h01, "R6 pending cleared");

        // R4 falling edge ignored in rising mode, R5 hold
        b_pad_in = 8'h55;
        step(3);
        b_strobe = 1'b0;
        step(4);
        bus_read(1, 2'd3, 8'h01, "R4 falling edge ignored");
        bus_read(1, 2'd2, 8'h3C, "R5 capture held");

        // R3 falling mode; R4 rising ignored
        bus_write(1, 2'd3, 8'h03);
        b_pad_in = 8'h99;
        step(3);
        b_strobe = 1'b1;
        step(4);
        check({7'd0, irq_n}, 8'h01, "R4 rising ignored in falling mode");
        bus_read(1, 2'd3, 8'h03, "R4 no pending in falling mode");
        b_strobe = 1'b0;
        step(4);
        check({7'd0, irq_n}, 8'h00, "R3 falling capture irq");
        bus_read(1, 2'd3, 8'h83, "R3 falling pending");

        // R9 shared line
        bus_write(0, 2'd3, 8'h01);
        a_pad_in = 8'h77;
        step(3);
        a_strobe = 1'b1;
        step(4);
        bus_read(1, 2'd2, 8'h99, "R3 falling capture value");
        check({7'd0, irq_n}, 8'h00, "R9 A still requests");
        bus_read(0, 2'd3, 8'h81, "R9 A pending");
        bus_read(0, 2'd2, 8'h77, "R9 A capture");
        check({7'd0, irq_n}, 8'h01, "R9 both serviced");

        // R7 same-cycle read and capture on A
        a_strobe = 1'b0;
        a_pad_in = 8'hE1;
        step(4);
        a_strobe = 1'b1;
        @(posedge clk);
        bus_read(0, 2'd2, 8'h77, "R7 read returns old capture");
        bus_read(0, 2'd3, 8'h81, "R7 pending survives race");
        check({7'd0, irq_n}, 8'h00, "R7 irq kept");
        bus_read(0, 2'd2, 8'hE1, "R7 new capture");
        bus_read(1, 2'd3, 8'h03, "R10 B ctrl unaffected");

        step(2);
        if (sb_q.size() != 0) begin
            vectors++;
            miscompares++;
            $display("FAIL scoreboard: got %0d leftover expected 0", sb_q.size());
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule